// File: doc/BRIEF.md
# Prescaled Multi-Mode Serial Master

This block is a synchronous serial master that sends and receives one word per transfer. The word is 4 to 16 bits long. A single 16-bit control word sets the clock mode, the frame width and a rate value. A separate prescale input completes the bit-rate setting. A host offers a word with a valid/ready handshake. The block then lowers the active-low frame select, toggles the serial clock and shifts the word out most significant bit first. At the same time it shifts the returning bits in from the data input line. When the frame closes, the received word is presented for one cycle.

The bit clock comes from two counters in cascade. The first divides by half of an even prescale value. The second counts up to an 8-bit rate value. One half of a bit period therefore lasts (P/2)·(1+R) input clocks. The control word, the prescale value and the transmit word are all captured when a write is accepted. They stay fixed until that frame ends, so the host may change its inputs freely while a frame is running.

Top module: `spm_top`

## Requirements
- R1: One half bit period H equals (P/2)·(1+R) clocks. P is the prescale input with bit 0 ignored, and a value below 2 acts as 2. R is control bits [15:8]. Every serial clock edge is H clocks after the previous one.
- R2: Control bits [5:0] hold the frame width minus one. Values below 3 give 4 bits and values above 15 give 16 bits. Bit 6 is the clock polarity and bit 7 is the clock phase.
- R3: Between frames the serial clock rests at the polarity of the last accepted frame, and it rests at 0 after reset. With phase 0 the data input is sampled on odd-numbered edges and new output data is launched on even edges. With phase 1 output data is launched on odd edges and the input is sampled on even edges.
- R4: A frame of W bits has exactly 2W serial clock edges. The bits go out most significant bit first.
- R5: Transmit word bits at W and above are ignored. In the received word, bits at W and above are zero.
- R6: Frame select goes low in the cycle after acceptance, H clocks before the first clock edge. It returns high H clocks after the last clock edge.
- R7: `busy` stays high for exactly (2W+1)·H cycles after acceptance, and `wr_ready` is its inverse. A write offered while busy is ignored and does not disturb the running frame.
- R8: `rd_valid` pulses for one cycle, in the cycle where `busy` falls, and `rd_data` then holds the received word.
- R9: After reset, frame select is high, the serial clock and data out are 0, `busy` and `rd_valid` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Control word: width−1 [5:0], polarity [6], phase [7], rate [15:8] |
| prescale | input | 8 | Even prescale value, 2 to 254 |
| wr_valid | input | 1 | A transmit word is offered |
| wr_data | input | 16 | Transmit word, right-aligned |
| wr_ready | output | 1 | The block can accept a word |
| rd_valid | output | 1 | One-cycle pulse: received word is valid |
| rd_data | output | 16 | Received word, right-aligned, upper bits zero |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low frame select |

## Verification
The assertions assume that `miso` is settled by the time the block samples it. They also assume that `wr_valid` is only an offer, so nothing is required of the host's data while the block is busy. The bench's slave model changes `miso` only on launch edges, which are at least one half bit period away from any sample edge. The bench holds `wr_valid` high during frames only to show that such writes are ignored, and it drops the offer before `busy` falls so that no stray frame starts.

// File: rtl/spm_pkg.sv
package spm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } spm_state_e;
endpackage

// File: rtl/spm_rate_gen.sv
module spm_rate_gen #(
   parameter int PS_W   = 8,
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PS_W-1:0]   ps_val,
   input  logic [RATE_W-1:0] rate_val,
   output logic              tick
);
   logic [PS_W-1:0]   half_div;
   logic [PS_W-1:0]   ps_cnt;
   logic [RATE_W-1:0] rt_cnt;
   logic              ps_term, rt_term;

   generate
      if (PS_W < 2) begin : g_bad_ps
         $error("spm_rate_gen: PS_W must be at least 2");
      end
   endgenerate

   always_comb begin
      half_div = ps_val >> 1;
      if (half_div == '0) half_div = PS_W'(1);
   end

   assign ps_term = (ps_cnt == half_div - PS_W'(1));
   assign rt_term = (rt_cnt == rate_val);
   assign tick    = run && ps_term && rt_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_cnt <= '0;
         rt_cnt <= '0;
      end else if (!run) begin
         ps_cnt <= '0;
         rt_cnt <= '0;
      end else if (ps_term) begin
         ps_cnt <= '0;
         rt_cnt <= rt_term ? '0 : rt_cnt + RATE_W'(1);
      end else begin
         ps_cnt <= ps_cnt + PS_W'(1);
      end
   end

   p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (ps_cnt == '0 && rt_cnt == '0));

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ps_cnt < half_div));
endmodule

// File: rtl/spm_shifter.sv
module spm_shifter
   import spm_pkg::*;
#(
   parameter int MAX_W = 16,
   parameter int WF_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MAX_W-1:0] tx_word,
   input  logic [WF_W-1:0]  wm1_in,
   input  logic             pol_in,
   input  logic             pha_in,
   input  logic             tick,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n,
   output logic             busy,
   output logic             rd_valid,
   output logic [MAX_W-1:0] rd_data
);
   localparam int EC_W = $clog2(2 * MAX_W + 1);

   spm_state_e       state;
   logic [MAX_W-1:0] tx_sr, rx_sr;
   logic [EC_W-1:0]  ec, last_ec;
   logic [WF_W-1:0]  wm1_q, align_sh;
   logic             pol_q, pha_q;
   logic             odd_edge, sample_edge, launch_edge;

   assign align_sh    = WF_W'(MAX_W - 1) - wm1_in;
   assign last_ec     = EC_W'({wm1_q, 1'b1});
   assign odd_edge    = ~ec[0];
   assign sample_edge = odd_edge ^ pha_q;
   assign launch_edge = ~sample_edge && (ec != '0);
   assign busy        = (state != ST_IDLE);
   assign mosi        = busy ? tx_sr[MAX_W-1] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sclk     <= 1'b0;
         cs_n     <= 1'b1;
         pol_q    <= 1'b0;
         pha_q    <= 1'b0;
         wm1_q    <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         ec       <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               pol_q <= pol_in;
               pha_q <= pha_in;
               sclk  <= pol_in;
               wm1_q <= wm1_in;
               tx_sr <= tx_word << align_sh;
               rx_sr <= '0;
               ec    <= '0;
               cs_n  <= 1'b0;
               state <= ST_SHIFT;
            end
            ST_SHIFT: if (tick) begin
               sclk <= ~sclk;
               ec   <= ec + EC_W'(1);
               if (sample_edge) rx_sr <= {rx_sr[MAX_W-2:0], miso};
               if (launch_edge) tx_sr <= {tx_sr[MAX_W-2:0], 1'b0};
               if (ec == last_ec) state <= ST_TAIL;
            end
            ST_TAIL: if (tick) begin
               cs_n     <= 1'b1;
               rd_valid <= 1'b1;
               rd_data  <= rx_sr;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (sclk == pol_q));

   p_edge_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (ec <= last_ec));

   p_tail_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL) |-> (sclk == pol_q));

   p_rdv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_rdv_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (!busy && cs_n));
endmodule

// File: rtl/spm_top.sv
module spm_top #(
   parameter int MAX_W  = 16,
   parameter int PS_W   = 8,
   parameter int RATE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATE_W+7:0]  cfg_word,
   input  logic [PS_W-1:0]    prescale,
   input  logic               wr_valid,
   input  logic [MAX_W-1:0]   wr_data,
   output logic               wr_ready,
   output logic               rd_valid,
   output logic [MAX_W-1:0]   rd_data,
   output logic               busy,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic               cs_n
);
   localparam int WF_W   = $clog2(MAX_W);
   localparam int FLD_W  = 6;
   localparam int MIN_M1 = 3;

   generate
      if (MAX_W < 4 || MAX_W > 2 ** FLD_W) begin : g_bad_w
         $error("spm_top: MAX_W out of range");
      end
   endgenerate

   logic [FLD_W-1:0]  wfld;
   logic [WF_W-1:0]   wm1;
   logic [PS_W-1:0]   ps_q;
   logic [RATE_W-1:0] rate_q;
   logic              start, tick;

   assign wfld     = cfg_word[FLD_W-1:0];
   assign wm1      = (wfld < FLD_W'(MIN_M1)) ? WF_W'(MIN_M1)
                   : (wfld > FLD_W'(MAX_W - 1)) ? WF_W'(MAX_W - 1)
                   : WF_W'(wfld);
   assign wr_ready = ~busy;
   assign start    = wr_valid && wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q   <= '0;
         rate_q <= '0;
      end else if (start) begin
         ps_q   <= prescale;
         rate_q <= cfg_word[RATE_W+7:8];
      end
   end

   spm_rate_gen #(.PS_W(PS_W), .RATE_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .ps_val(ps_q), .rate_val(rate_q), .tick(tick)
   );

   spm_shifter #(.MAX_W(MAX_W), .WF_W(WF_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(wr_data),
      .wm1_in(wm1), .pol_in(cfg_word[6]), .pha_in(cfg_word[7]),
      .tick(tick), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ps_q) && $stable(rate_q)));

   p_select_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !cs_n);
endmodule

// File: tb/sim_spm_top.sv
module sim_spm_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [7:0]  prescale = 8'd2;
   logic        wr_valid = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wr_ready, rd_valid, busy, sclk, mosi, cs_n;
   logic [15:0] rd_data;
   logic        miso = 1'b0;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spm_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .prescale(prescale),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .sclk(sclk),
      .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // slave model
   bit          s_act = 1'b0;
   bit          s_pha = 1'b0;
   int          s_idx = 0, s_ecnt = 0;
   logic [15:0] s_word = '0, s_cap = '0;

   always @(sclk) begin
      if (s_act) begin
         s_ecnt = s_ecnt + 1;
         if ((s_ecnt % 2 == 1) != s_pha) s_cap = {s_cap[14:0], mosi};
         else if (s_idx >= 0) begin
            miso  = s_word[s_idx];
            s_idx = s_idx - 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic int exp_half(input logic [7:0] ps, input logic [7:0] rate);
      int h = int'(ps >> 1);
      if (h == 0) h = 1;
      return h * (int'(rate) + 1);
   endfunction

   function automatic int exp_width(input logic [5:0] f);
      if (f < 6'd3) return 4;
      if (f > 6'd15) return 16;
      return int'(f) + 1;
   endfunction

   task automatic xfer(input logic [15:0] cfg, input logic [7:0] ps,
                       input logic [15:0] tx, input logic [15:0] sw, input bit poke);
      int w    = exp_width(cfg[5:0]);
      int h    = exp_half(ps, cfg[15:8]);
      logic [15:0] mask = 16'((32'h1 << w) - 1);
      logic pol = cfg[6];
      logic pha = cfg[7];
      int nb = 0, lead = 0, edges = 0;
      logic prev;
      @(negedge clk);
      cfg_word = cfg; prescale = ps; wr_data = tx; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      s_word = sw; s_pha = pha; s_ecnt = 0; s_cap = '0;
      if (!pha) begin miso = sw[w-1]; s_idx = w - 2; end
      else s_idx = w - 1;
      s_act = 1'b1;
      prev = pol;
      while (busy && nb < 100000) begin
         nb++;
         if (sclk !== prev) begin edges++; prev = sclk; end
         if (edges == 0) lead++;
         if (nb == 2) begin
            check("R7 ready low while busy", wr_ready, 0);
            check("R6 select low in frame", cs_n, 0);
         end
         if (poke) begin
            wr_valid = (nb < 4);
            wr_data  = 16'hFFFF;
            cfg_word = 16'h0040 ^ cfg;
         end
         @(negedge clk);
      end
      s_act = 1'b0;
      check("R7 busy length", nb, (2 * w + 1) * h);
      check("R6 lead before first edge", lead, h);
      check("R4 edge count", edges, 2 * w);
      check("R8 rd_valid at end", rd_valid, 1);
      check("R5 received word", rd_data, sw & mask);
      check("R4 captured at slave", s_cap & mask, tx & mask);
      check("R6 select released", cs_n, 1);
      check("R3 clock rests at polarity", sclk, pol);
      @(negedge clk);
      check("R8 single pulse", rd_valid, 0);
   endtask

   // cfg[15:0], prescale[7:0], tx[15:0], slave word[15:0]
   localparam logic [55:0] VEC [7] = '{
      {16'h0007, 8'd2,   16'h00A5, 16'h003C},  // R2 mode 0, 8 bits
      {16'h018F, 8'd4,   16'hBEEF, 16'h1234},  // R1 mode 1, 16 bits
      {16'h0243, 8'd2,   16'hFFFF, 16'h0009},  // R5 mode 2, 4 bits
      {16'h00CB, 8'd6,   16'h0ABC, 16'h05A5},  // R3 mode 3, 12 bits
      {16'h0004, 8'd254, 16'h0013, 16'h000E},  // R1 largest prescale
      {16'h034F, 8'd2,   16'h8001, 16'h7FFE},  // R3 mode 2, 16 bits
      {16'hFF83, 8'd2,   16'h000A, 16'h0005}   // R1 largest rate
   };

   initial begin
      #(1_500_000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 cs_n", cs_n, 1);
      check("R9 sclk", sclk, 0);
      check("R9 mosi", mosi, 0);
      check("R9 busy", busy, 0);
      check("R9 ready", wr_ready, 1);
      check("R9 rd_valid", rd_valid, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 7; i++)
         xfer(VEC[i][55:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
      // R2 width field below 3 acts as 4 bits
      xfer(16'h0001, 8'd2, 16'h00F3, 16'h000C, 1'b0);
      // R2 width field above 15 acts as 16 bits
      xfer(16'h003F, 8'd2, 16'hC3A5, 16'h5AA5, 1'b0);
      // R1 odd prescale and zero prescale
      xfer(16'h0107, 8'd3, 16'h0055, 16'h00AA, 1'b0);
      xfer(16'h00C7, 8'd0, 16'h0081, 16'h0042, 1'b0);
      // R7 writes offered while busy are ignored
      xfer(16'h0209, 8'd4, 16'h0123, 16'h02CD, 1'b1);
      @(negedge clk);
      check("R7 no frame from ignored write", busy, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule